// File: doc/BRIEF.md
# Smart Card Contact Sequencer

This block is the digital controller that sits between a host processor and the contacts of one smart card slot. The host asks for a card session by pulling an active-low session command low. If a card is detected, the block powers the card in a fixed order, with a fixed number of clock cycles between steps: supply first, then the data line, then the card clock, and finally the reset contact, which from then on follows the host's reset input. When the host releases the command, the steps run in the opposite order.

Card detection and the three fault flags (supply, thermal, over-current) come from the analog side and are asynchronous, so each one passes through a two-stage synchronizer before use. Any fault during a session, including loss of the card, starts the power-off sequence without waiting for the host. An active-low interrupt line shows card presence while no session runs and a latched fault while the host holds the session command low. A power-down request is honoured only while the slot is idle. The card clock is the input clock divided by 1, 2 or 4, chosen by a two-bit code. The divided ratios come from counter flops and so have an exact 50% duty cycle.

Top module: `sc_seq_ctrl`

## Requirements
- R1: With `act_n` low, the host command armed and a card detected after synchronization, `card_vcc_en` goes high at the next clock edge. The supply-voltage select `volt_sel` is captured at that same edge.
- R2: A session request with no card detected has no effect: `card_vcc_en` stays low.
- R3: During power-up, `card_io_en` rises STEP_CYC cycles after the supply, the card clock starts 2*STEP_CYC cycles after the supply, and the reset contact is released 3*STEP_CYC cycles after the supply.
- R4: `card_rst` is held low until power-up completes. After that it equals `host_rst` in the same cycle.
- R5: When `act_n` goes high during a session, `card_rst` goes low at the next edge. The clock stops STEP_CYC cycles later, `card_io_en` falls after 2*STEP_CYC and `card_vcc_en` falls after 3*STEP_CYC.
- R6: A fault input, or loss of card detection, during a session is used after two synchronizer cycles. The power-off sequence then starts at the following edge (3 cycles after the input changes), with no host action.
- R7: `irq_n` = (synchronized card presence) AND NOT (fault latch). The fault latch is set when a fault ends a session while `act_n` is low. It is cleared at the first edge with `act_n` high.
- R8: Once a session ends, no new session starts until `act_n` has been seen high for at least one edge.
- R9: `pwr_dn_req` moves the block into power-down (`pd_mode` high) only from idle. During a session it has no effect. While the block is in power-down, session requests are ignored.
- R10: `div_code` selects the card clock: 2'b00 gives the input clock divided by 4, 2'b10 gives it divided by 2, and 2'b01 and 2'b11 pass the input clock through.
- R11: The divided card clock has exactly 50% duty. It is held low while the clock step is off.
- R12: `card_vsel` keeps the value it captured at power-up for the whole session, even if `volt_sel` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the source of the card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_n | input | 1 | Active-low session command from the host |
| pwr_dn_req | input | 1 | Host power-down request |
| host_rst | input | 1 | Host value for the card reset contact |
| volt_sel | input | 1 | Host card supply voltage select |
| div_code | input | 2 | Card clock divide code |
| card_det | input | 1 | Card presence, asynchronous |
| flt_volt | input | 1 | Supply fault flag, asynchronous |
| flt_therm | input | 1 | Thermal fault flag, asynchronous |
| flt_ocp | input | 1 | Over-current fault flag, asynchronous |
| irq_n | output | 1 | Active-low host interrupt |
| card_vcc_en | output | 1 | Card supply enable |
| card_vsel | output | 1 | Captured supply voltage select |
| card_io_en | output | 1 | Card data line enable |
| card_clk | output | 1 | Card clock contact |
| card_rst | output | 1 | Card reset contact |
| pd_mode | output | 1 | Block is in power-down |

## Verification
Every result has a fixed due cycle relative to the clock edge that first sees the stimulus:
- supply and voltage capture at +1;
- data line at +1+STEP_CYC;
- clock at +1+2*STEP_CYC;
- reset release at +1+3*STEP_CYC;
- host release effects at the same offsets;
- fault responses and card-presence changes two cycles later, because of the synchronizer.

The driver pushes each expected value with its due cycle into a queue. The monitor compares it at that exact sample, and for the timed steps it also checks the cycle just before. Duty and pass-through behaviour of the card clock are measured by sampling across whole periods, in both clock phases.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UP    = 3'd1,
    ST_ON    = 3'd2,
    ST_DOWN  = 3'd3,
    ST_PD    = 3'd4
  } seq_st_e;

  // bit 0 presence, bits 3:1 fault flags
  localparam int unsigned STAT_W = 4;

  // log2 of the divide ratio for a divide code
  function automatic logic [1:0] div_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd2;
      2'b10:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // session-ending condition from synchronized status
  function automatic logic stat_fault(input logic [STAT_W-1:0] s);
    return (!s[0]) | (|s[STAT_W-1:1]);
  endfunction

endpackage

// File: rtl/sc_sync2.sv
module sc_sync2 #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d_async[b];
        st2 <= st1;
      end
    end
    assign q_sync[b] = st2;
  end
endmodule

// File: rtl/sc_clkdiv.sv
module sc_clkdiv
  import sc_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  output logic       card_clk
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       shift_w;

  assign shift_w = div_shift(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (shift_w)
      2'd0:    card_clk = run & clk;
      2'd1:    card_clk = run & cnt_q[0];
      default: card_clk = run & cnt_q[1];
    endcase
  end

  // R11
  div_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (cnt_q != $past(cnt_q)));

  // R11
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (cnt_q == '0));
endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import sc_seq_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_n,
  input  logic              pwr_dn_req,
  input  logic              volt_sel,
  input  logic [STAT_W-1:0] stat_s,
  output logic              vcc_en,
  output logic              io_en,
  output logic              clk_en,
  output logic              rst_en,
  output logic              vsel,
  output logic              pd_mode,
  output logic              flt_lat
);
  localparam int unsigned TW = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;

  seq_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic [1:0]    stg_q;
  logic          armed_q;

  // named events for checks
  logic present_w, fault_w, step_done_w, go_down_w, start_w;
  assign present_w   = stat_s[0];
  assign fault_w     = stat_fault(stat_s);
  assign step_done_w = (tmr_q == TW'(STEP_CYC - 1));
  assign go_down_w   = fault_w | act_n;
  assign start_w     = (st_q == ST_IDLE) && !pwr_dn_req && !act_n && armed_q && present_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      stg_q   <= '0;
      armed_q <= 1'b0;
      vcc_en  <= 1'b0;
      io_en   <= 1'b0;
      clk_en  <= 1'b0;
      rst_en  <= 1'b0;
      vsel    <= 1'b0;
      flt_lat <= 1'b0;
    end else begin
      if (act_n) begin
        armed_q <= 1'b1;
        flt_lat <= 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (pwr_dn_req) st_q <= ST_PD;
          else if (start_w) begin
            st_q    <= ST_UP;
            vcc_en  <= 1'b1;
            vsel    <= volt_sel;
            tmr_q   <= '0;
            stg_q   <= '0;
            armed_q <= 1'b0;
          end
        end
        ST_PD: if (!pwr_dn_req) st_q <= ST_IDLE;
        ST_UP, ST_ON: begin
          if (go_down_w) begin
            st_q   <= ST_DOWN;
            tmr_q  <= '0;
            stg_q  <= '0;
            rst_en <= 1'b0;
            if (fault_w && !act_n) flt_lat <= 1'b1;
          end else if (st_q == ST_UP) begin
            if (step_done_w) begin
              tmr_q <= '0;
              stg_q <= stg_q + 2'd1;
              case (stg_q)
                2'd0:    io_en  <= 1'b1;
                2'd1:    clk_en <= 1'b1;
                default: begin
                  rst_en <= 1'b1;
                  st_q   <= ST_ON;
                end
              endcase
            end else tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_DOWN: begin
          if (step_done_w) begin
            tmr_q <= '0;
            stg_q <= stg_q + 2'd1;
            case (stg_q)
              2'd0:    clk_en <= 1'b0;
              2'd1:    io_en  <= 1'b0;
              default: begin
                vcc_en <= 1'b0;
                st_q   <= ST_IDLE;
              end
            endcase
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pd_mode = (st_q == ST_PD);

  // R3
  supply_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_en |-> (!io_en && !clk_en && !rst_en));

  // R4
  rst_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_en |-> (clk_en && io_en && vcc_en));

  // R6
  fault_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && fault_w && !act_n) |=> (st_q == ST_DOWN && !rst_en && flt_lat));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !armed_q && !act_n) |=> (st_q != ST_UP));

  // R9
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_mode |-> !vcc_en);

  // R12
  vsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && $past(st_q == ST_ON)) |-> $stable(vsel));
endmodule

// File: rtl/sc_seq_ctrl.sv
module sc_seq_ctrl
  import sc_seq_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4,
  parameter int unsigned DIV_W    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_n,
  input  logic       pwr_dn_req,
  input  logic       host_rst,
  input  logic       volt_sel,
  input  logic [1:0] div_code,
  input  logic       card_det,
  input  logic       flt_volt,
  input  logic       flt_therm,
  input  logic       flt_ocp,
  output logic       irq_n,
  output logic       card_vcc_en,
  output logic       card_vsel,
  output logic       card_io_en,
  output logic       card_clk,
  output logic       card_rst,
  output logic       pd_mode
);
  logic [STAT_W-1:0] stat_s;
  logic clk_en, rst_en, flt_lat;

  sc_sync2 #(.W(STAT_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({flt_ocp, flt_therm, flt_volt, card_det}),
    .q_sync  (stat_s)
  );

  sc_sequencer #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_n      (act_n),
    .pwr_dn_req (pwr_dn_req),
    .volt_sel   (volt_sel),
    .stat_s     (stat_s),
    .vcc_en     (card_vcc_en),
    .io_en      (card_io_en),
    .clk_en     (clk_en),
    .rst_en     (rst_en),
    .vsel       (card_vsel),
    .pd_mode    (pd_mode),
    .flt_lat    (flt_lat)
  );

  sc_clkdiv #(.CNT_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (clk_en),
    .code     (div_code),
    .card_clk (card_clk)
  );

  assign irq_n    = stat_s[0] & ~flt_lat;
  assign card_rst = rst_en & host_rst;

  // R7
  irq_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_lat && !act_n) |-> !irq_n);
endmodule

// File: tb/sc_seq_ctrl_test.sv
module sc_seq_ctrl_test;
  localparam int S = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, act_n, pwr_dn_req, host_rst, volt_sel, card_det, flt_volt, flt_therm, flt_ocp;
  logic [1:0] div_code;
  logic irq_n, card_vcc_en, card_vsel, card_io_en, card_clk, card_rst, pd_mode;

  sc_seq_ctrl #(.STEP_CYC(S)) uut (
    .clk(clk), .rst_n(rst_n), .act_n(act_n), .pwr_dn_req(pwr_dn_req),
    .host_rst(host_rst), .volt_sel(volt_sel), .div_code(div_code),
    .card_det(card_det), .flt_volt(flt_volt), .flt_therm(flt_therm), .flt_ocp(flt_ocp),
    .irq_n(irq_n), .card_vcc_en(card_vcc_en), .card_vsel(card_vsel),
    .card_io_en(card_io_en), .card_clk(card_clk), .card_rst(card_rst), .pd_mode(pd_mode)
  );

  typedef struct {int due; int sid; logic val; string req;} exp_t;
  exp_t exq[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic observe(int sid);
    case (sid)
      0: return card_vcc_en;
      1: return card_io_en;
      2: return card_clk;
      3: return card_rst;
      4: return irq_n;
      5: return pd_mode;
      default: return card_vsel;
    endcase
  endfunction

  function automatic string sname(int sid);
    case (sid)
      0: return "card_vcc_en";
      1: return "card_io_en";
      2: return "card_clk";
      3: return "card_rst";
      4: return "irq_n";
      5: return "pd_mode";
      default: return "card_vsel";
    endcase
  endfunction

  task automatic expect_at(int d, int sid, logic v, string req);
    exq.push_back('{cyc + d, sid, v, req});
  endtask

  task automatic check_now(logic act, logic exp, string what, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // monitor: sample 5 ns after each rising edge
  always begin
    @(posedge clk);
    #5;
    cyc++;
    for (int i = exq.size() - 1; i >= 0; i--) begin
      if (exq[i].due == cyc) begin
        n_cmp++;
        if (observe(exq[i].sid) !== exq[i].val) begin
          n_bad++;
          $display("FAIL %s %s at cycle %0d actual=%b expected=%b", exq[i].req,
                   sname(exq[i].sid), cyc, observe(exq[i].sid), exq[i].val);
        end
        exq.delete(i);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // count high samples and changes across 9 rising-edge samples
  task automatic clock_shape(output int highs, output int changes);
    logic prev, cur;
    highs = 0;
    changes = 0;
    @(posedge clk); #5; prev = card_clk;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #5; cur = card_clk;
      if (cur) highs++;
      if (cur != prev) changes++;
      prev = cur;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
  end

  initial begin
    int hi, ch;
    rst_n = 0; act_n = 1; pwr_dn_req = 0; host_rst = 0; volt_sel = 0;
    div_code = 2'b01; card_det = 0; flt_volt = 0; flt_therm = 0; flt_ocp = 0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // reset state
    expect_at(1, 0, 1'b0, "R1 reset");
    expect_at(1, 4, 1'b0, "R7 reset no card");
    expect_at(1, 5, 1'b0, "R9 reset");
    wait_cyc(2);

    // R2: request without card
    act_n = 0;
    expect_at(1, 0, 1'b0, "R2");
    expect_at(10, 0, 1'b0, "R2");
    expect_at(10, 4, 1'b0, "R7 no card");
    wait_cyc(12);
    act_n = 1;
    wait_cyc(2);

    // card insertion visible after synchronizer
    card_det = 1;
    expect_at(1, 4, 1'b0, "R7 sync delay");
    expect_at(2, 4, 1'b1, "R7 presence");
    wait_cyc(4);

    // R9: power-down from idle, session ignored meanwhile
    pwr_dn_req = 1;
    expect_at(1, 5, 1'b1, "R9 enter");
    wait_cyc(2);
    act_n = 0;
    expect_at(8, 0, 1'b0, "R9 request ignored");
    wait_cyc(10);
    act_n = 1;
    pwr_dn_req = 0;
    expect_at(1, 5, 1'b0, "R9 leave");
    wait_cyc(3);

    // R1 R3 R4 R12: power-up order
    host_rst = 1; volt_sel = 1; div_code = 2'b01;
    wait_cyc(1);
    act_n = 0;
    expect_at(1, 0, 1'b1, "R1");
    expect_at(1, 6, 1'b1, "R12 capture");
    expect_at(S, 1, 1'b0, "R3 io early");
    expect_at(S + 1, 1, 1'b1, "R3 io");
    expect_at(2 * S, 2, 1'b0, "R3 clk early");
    expect_at(2 * S + 1, 2, 1'b1, "R3 clk");
    expect_at(3 * S, 3, 1'b0, "R4 held");
    expect_at(3 * S + 1, 3, 1'b1, "R4 released");
    wait_cyc(3 * S + 4);

    // R12 voltage select frozen, R4 follow host reset
    volt_sel = 0;
    host_rst = 0;
    expect_at(1, 3, 1'b0, "R4 follow low");
    expect_at(3, 6, 1'b1, "R12 hold");
    wait_cyc(1);
    host_rst = 1;
    expect_at(1, 3, 1'b1, "R4 follow high");
    wait_cyc(2);

    // R9 ignored in session
    pwr_dn_req = 1;
    expect_at(3, 5, 1'b0, "R9 in session");
    expect_at(3, 0, 1'b1, "R9 supply kept");
    wait_cyc(4);
    pwr_dn_req = 0;
    wait_cyc(1);

    // R10 R11 divide ratios
    div_code = 2'b00;
    clock_shape(hi, ch);
    check_now(hi == 4, 1'b1, "div4 duty", "R11");
    check_now(ch == 4, 1'b1, "div4 period", "R10");
    div_code = 2'b10;
    clock_shape(hi, ch);
    check_now(hi == 4, 1'b1, "div2 duty", "R11");
    check_now(ch == 8, 1'b1, "div2 period", "R10");
    div_code = 2'b11;
    @(posedge clk); #5;
    check_now(card_clk, 1'b1, "code 11 high phase", "R10");
    @(negedge clk); #5;
    check_now(card_clk, 1'b0, "code 11 low phase", "R10");
    div_code = 2'b01;
    @(posedge clk); #5;
    check_now(card_clk, 1'b1, "code 01 high phase", "R10");
    @(negedge clk); #5;
    check_now(card_clk, 1'b0, "code 01 low phase", "R10");
    wait_cyc(1);

    // R5 power-down order on host release
    act_n = 1;
    expect_at(1, 3, 1'b0, "R5 reset first");
    expect_at(S, 2, 1'b1, "R5 clk kept");
    expect_at(S + 1, 2, 1'b0, "R5 clk stop");
    expect_at(2 * S, 1, 1'b1, "R5 io kept");
    expect_at(2 * S + 1, 1, 1'b0, "R5 io off");
    expect_at(3 * S, 0, 1'b1, "R5 supply kept");
    expect_at(3 * S + 1, 0, 1'b0, "R5 supply off");
    expect_at(3 * S + 4, 4, 1'b1, "R7 no fault on release");
    wait_cyc(3 * S + 6);

    // R6 R7 fault mid-session
    act_n = 0;
    wait_cyc(3 * S + 4);
    flt_ocp = 1;
    expect_at(2, 3, 1'b1, "R6 not yet");
    expect_at(3, 3, 1'b0, "R6 auto deactivation");
    expect_at(2, 4, 1'b1, "R7 not yet");
    expect_at(3, 4, 1'b0, "R7 fault flag");
    expect_at(3 * S + 3, 0, 0, "R6 supply off");
    wait_cyc(3 * S + 6);
    flt_ocp = 0;

    // R8 no restart while command stays low, R7 latch held
    expect_at(10, 0, 1'b0, "R8 no restart");
    expect_at(10, 4, 1'b0, "R7 latch held");
    wait_cyc(12);
    act_n = 1;
    expect_at(1, 4, 1'b1, "R7 latch cleared");
    wait_cyc(2);
    act_n = 0;
    expect_at(1, 0, 1'b1, "R8 rearmed");
    wait_cyc(3 * S + 4);

    // R6 card removal mid-session
    card_det = 0;
    expect_at(3, 3, 1'b0, "R6 removal");
    expect_at(3, 4, 1'b0, "R7 removal");
    wait_cyc(3 * S + 6);
    act_n = 1;
    expect_at(1, 4, 1'b0, "R7 no card after release");
    expect_at(1, 0, 1'b0, "R6 supply off after removal");
    wait_cyc(4);

    summary();
  end
endmodule